// File: doc/BRIEF.md
# Sync Word Search Detector

This block watches a demodulated serial bit stream, one bit per strobe, and reports when the most recent sixteen received bits form one of two fixed synchronization words. A control input picks which word to look for. The primary word serves first-time lock. The alternate word is available for tracking an established link.

A two-bit mode input sets the search behaviour. The search can be off. In acquisition, a match counts at any bit position. In tracking, a match counts only when the bit-position count from the frame timer lies within a small tolerance of a programmed expected position; the distance wraps around the position range. An accepted match raises a sticky indicator and stores the bit position at which the final bit of the word arrived. Software drops the indicator with a clear strobe.

Top module: `syncdet_top`

## Requirements
- R1: After reset, `acq_ind` is 0 and `acq_loc` is 0.
- R2: A candidate word is formed only from bits presented with `bit_vld` high. Cycles with `bit_vld` low leave it unchanged, whatever `bit_in` is. The oldest of the last 16 valid bits is compared with bit 15 of the pattern, and the newest with bit 0.
- R3: With `word_sel` = 0 the pattern is 16'h46A5, the primary word. With `word_sel` = 1 it is 16'hD93E, the alternate word. The unselected pattern never produces a match.
- R4: With `srch_mode` = 2'b00, no match is accepted.
- R5: With `srch_mode` = 2'b01, a match is accepted at any value of `bit_pos`.
- R6: With `srch_mode` = 2'b10 or 2'b11, a match is accepted only when `bit_pos` lies within `exp_pos` ± 2, inclusive, with the distance taken modulo 512.
- R7: `acq_ind` stays 1 until a cycle with `ind_clr` high and no accepted match. It reads 0 from the following cycle.
- R8: When `ind_clr` and an accepted match occur in the same cycle, `acq_ind` stays 1 and `acq_loc` takes the new position.
- R9: On each accepted match, `acq_loc` takes the `bit_pos` value present with the word's final bit. At all other times it holds its value.
- R10: No match is accepted until 16 valid bits have arrived since reset.
- R11: A match completed by a valid bit is visible on `acq_ind` and `acq_loc` in the cycle after that bit was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Demodulated data bit |
| bit_vld | input | 1 | Strobe marking `bit_in` as a new bit |
| bit_pos | input | 9 | Frame-relative bit position of the current bit |
| word_sel | input | 1 | Pattern select: 0 primary, 1 alternate |
| srch_mode | input | 2 | 00 off, 01 acquisition, 10/11 tracking |
| exp_pos | input | 9 | Expected word end position for tracking |
| ind_clr | input | 1 | Clear strobe for the indicator |
| acq_ind | output | 1 | Sticky match indicator |
| acq_loc | output | 9 | Bit position of the last accepted match |

## Verification
Some rules are checked on every cycle. The indicator must stay set without a clear, must drop after a clear with no match, and must rise with the captured position after an accepted match. The location must hold when there is no match. Nothing may be accepted while the search is off, or in tracking outside the wrapped window. Other behaviours only the directed scenarios can show. These are the exact bit ordering and pattern values, the fill period after reset, and immunity to gaps in the strobe. The window edges, including wrap around position 0, and the clear colliding with a match also need the scenarios.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;
   typedef enum logic [1:0] {
      SM_OFF  = 2'b00,
      SM_ACQ  = 2'b01,
      SM_TRK  = 2'b10,
      SM_TRK2 = 2'b11
   } srch_mode_e;
endpackage

// File: rtl/syncdet_shreg.sv
module syncdet_shreg #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic              bit_vld,
   output logic [WORD_W-1:0] cand,
   output logic              primed
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  fill_q;

   // candidate includes the bit being presented this cycle
   assign cand   = {sr_q[WORD_W-2:0], bit_in};
   assign primed = (fill_q == FULL_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         fill_q <= '0;
      end else if (bit_vld) begin
         sr_q <= cand;
         if (!primed) fill_q <= fill_q + 1'b1;
      end
   end
endmodule

// File: rtl/syncdet_cmp.sv
module syncdet_cmp #(
   parameter int              WORD_W = 16,
   parameter logic [WORD_W-1:0] PAT_A = 16'h46A5,
   parameter logic [WORD_W-1:0] PAT_B = 16'hD93E
) (
   input  logic [WORD_W-1:0] cand,
   input  logic              word_sel,
   output logic              eq
);
   logic [WORD_W-1:0] ref_w;
   logic [WORD_W-1:0] agree;

   assign ref_w = word_sel ? PAT_B : PAT_A;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign agree[i] = ~(cand[i] ^ ref_w[i]);
   end

   assign eq = &agree;
endmodule

// File: rtl/syncdet_window.sv
module syncdet_window #(
   parameter int POS_W   = 9,
   parameter int WIN_TOL = 2
) (
   input  logic [POS_W-1:0] bit_pos,
   input  logic [POS_W-1:0] exp_pos,
   output logic             in_win
);
   if (WIN_TOL == 0) begin : g_exact
      assign in_win = (bit_pos == exp_pos);
   end else begin : g_range
      localparam logic [POS_W-1:0] TOL_V = POS_W'(WIN_TOL);
      logic [POS_W-1:0] ahead;
      logic [POS_W-1:0] behind;
      assign ahead  = bit_pos - exp_pos;
      assign behind = exp_pos - bit_pos;
      assign in_win = (ahead <= TOL_V) || (behind <= TOL_V);
   end
endmodule

// File: rtl/syncdet_top.sv
module syncdet_top #(
   parameter int              WORD_W  = 16,
   parameter int              POS_W   = 9,
   parameter int              WIN_TOL = 2,
   parameter logic [WORD_W-1:0] PAT_A = 16'h46A5,
   parameter logic [WORD_W-1:0] PAT_B = 16'hD93E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   input  logic             bit_vld,
   input  logic [POS_W-1:0] bit_pos,
   input  logic             word_sel,
   input  logic [1:0]       srch_mode,
   input  logic [POS_W-1:0] exp_pos,
   input  logic             ind_clr,
   output logic             acq_ind,
   output logic [POS_W-1:0] acq_loc
);
   import syncdet_pkg::*;

   if (WORD_W < 2) begin : g_bad_word
      $error("syncdet_top: WORD_W must be at least 2");
   end
   if (POS_W < 2) begin : g_bad_pos
      $error("syncdet_top: POS_W must be at least 2");
   end
   if (2 * WIN_TOL >= (1 << POS_W)) begin : g_bad_tol
      $error("syncdet_top: window covers the whole position range");
   end
   if (PAT_A == PAT_B) begin : g_bad_pat
      $error("syncdet_top: patterns must differ");
   end

   logic [WORD_W-1:0] cand;
   logic              primed;
   logic              eq;
   logic              in_win;
   logic              mode_ok;
   logic              hit;
   srch_mode_e        mode;

   syncdet_shreg #(.WORD_W(WORD_W)) shreg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (bit_in),
      .bit_vld(bit_vld),
      .cand   (cand),
      .primed (primed)
   );

   syncdet_cmp #(.WORD_W(WORD_W), .PAT_A(PAT_A), .PAT_B(PAT_B)) cmp_i (
      .cand    (cand),
      .word_sel(word_sel),
      .eq      (eq)
   );

   syncdet_window #(.POS_W(POS_W), .WIN_TOL(WIN_TOL)) win_i (
      .bit_pos(bit_pos),
      .exp_pos(exp_pos),
      .in_win (in_win)
   );

   assign mode = srch_mode_e'(srch_mode);

   always_comb begin
      case (mode)
         SM_OFF:  mode_ok = 1'b0;
         SM_ACQ:  mode_ok = 1'b1;
         default: mode_ok = in_win;
      endcase
   end

   assign hit = bit_vld & primed & eq & mode_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acq_ind <= 1'b0;
         acq_loc <= '0;
      end else if (hit) begin
         acq_ind <= 1'b1;
         acq_loc <= bit_pos;
      end else if (ind_clr) begin
         acq_ind <= 1'b0;
      end
   end
endmodule

// File: rtl/syncdet_chk.sv
module syncdet_chk #(
   parameter int POS_W   = 9,
   parameter int WIN_TOL = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit,
   input logic             ind_clr,
   input logic [1:0]       srch_mode,
   input logic [POS_W-1:0] bit_pos,
   input logic [POS_W-1:0] exp_pos,
   input logic             acq_ind,
   input logic [POS_W-1:0] acq_loc
);
   logic [POS_W-1:0] shifted;
   logic             near;
   assign shifted = bit_pos + POS_W'(WIN_TOL) - exp_pos;
   assign near    = (shifted <= POS_W'(2 * WIN_TOL));

   AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (acq_ind && acq_loc == $past(bit_pos)));                      // R9
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_ind && !ind_clr) |=> acq_ind);                                   // R7
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_clr && !hit) |=> !acq_ind);                                      // R7
   AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_clr && hit) |=> acq_ind);                                        // R8
   AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(acq_loc));                                           // R9
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_mode == 2'b00) |-> !hit);                                       // R4
   AST_TRACK_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && srch_mode[1]) |-> near);                                      // R6
endmodule

bind syncdet_top syncdet_chk #(.POS_W(POS_W), .WIN_TOL(WIN_TOL)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit      (hit),
   .ind_clr  (ind_clr),
   .srch_mode(srch_mode),
   .bit_pos  (bit_pos),
   .exp_pos  (exp_pos),
   .acq_ind  (acq_ind),
   .acq_loc  (acq_loc)
);

// File: tb/syncdet_top_tb_top.sv
module syncdet_top_tb_top;
   localparam int CLK_P = 10;
   localparam logic [15:0] WA = 16'h46A5;
   localparam logic [15:0] WB = 16'hD93E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_vld = 1'b0;
   logic [8:0] bit_pos = '0;
   logic       word_sel = 1'b0;
   logic [1:0] srch_mode = 2'b00;
   logic [8:0] exp_pos = '0;
   logic       ind_clr = 1'b0;
   logic       acq_ind;
   logic [8:0] acq_loc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   syncdet_top dut_i (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .bit_pos(bit_pos), .word_sel(word_sel), .srch_mode(srch_mode),
      .exp_pos(exp_pos), .ind_clr(ind_clr), .acq_ind(acq_ind), .acq_loc(acq_loc)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic check_out(input string req, input logic e_ind, input logic [8:0] e_loc);
      chk(acq_ind === e_ind, {req, " acq_ind"}, int'(acq_ind), int'(e_ind));
      chk(acq_loc === e_loc, {req, " acq_loc"}, int'(acq_loc), int'(e_loc));
   endtask

   // called at a negedge; returns at the next negedge with results visible
   task automatic drive_bit(input logic b, input logic [8:0] p, input logic clr);
      bit_in = b; bit_vld = 1'b1; bit_pos = p; ind_clr = clr;
      @(negedge clk);
      bit_vld = 1'b0; ind_clr = 1'b0; bit_in = ~b;
   endtask

   task automatic send_word(input logic [15:0] w, input logic [8:0] end_p,
                            input logic clr_last, input bit gaps);
      for (int i = 15; i >= 0; i--) begin
         drive_bit(w[i], end_p - 9'(i), clr_last && (i == 0));
         if (gaps && i != 0) begin
            bit_in = ~w[i];
            @(negedge clk);
         end
      end
   endtask

   task automatic pulse_clr();
      ind_clr = 1'b1;
      @(negedge clk);
      ind_clr = 1'b0;
   endtask

   task automatic t_reset();
      check_out("R1 reset", 1'b0, 9'd0);
   endtask

   task automatic t_fill();
      srch_mode = 2'b01; word_sel = 1'b0;
      // zeros already in register plus A[14:0] equals A, but only 15 bits seen
      for (int i = 14; i >= 0; i--) drive_bit(WA[i], 9'd20 - 9'(i), 1'b0);
      check_out("R10 fill", 1'b0, 9'd0);
   endtask

   task automatic t_acq();
      srch_mode = 2'b01; word_sel = 1'b0;
      send_word(WA, 9'd100, 1'b0, 1'b0);
      check_out("R5 R11 acquisition match", 1'b1, 9'd100);
      send_word(16'hFFFF, 9'd300, 1'b0, 1'b0);
      check_out("R7 R9 sticky and hold", 1'b1, 9'd100);
      pulse_clr();
      check_out("R7 clear", 1'b0, 9'd100);
   endtask

   task automatic t_select();
      srch_mode = 2'b01; word_sel = 1'b1;
      send_word(WA, 9'd50, 1'b0, 1'b0);
      check_out("R3 unselected word ignored", 1'b0, 9'd100);
      send_word(WB, 9'd60, 1'b0, 1'b0);
      check_out("R3 alternate word", 1'b1, 9'd60);
      pulse_clr();
   endtask

   task automatic t_gaps();
      srch_mode = 2'b01; word_sel = 1'b1;
      send_word(WB, 9'd77, 1'b0, 1'b1);
      check_out("R2 invalid cycles skipped", 1'b1, 9'd77);
      pulse_clr();
   endtask

   task automatic t_off();
      srch_mode = 2'b00; word_sel = 1'b0;
      send_word(WA, 9'd150, 1'b0, 1'b0);
      check_out("R4 search off", 1'b0, 9'd77);
   endtask

   task automatic t_track();
      word_sel = 1'b0; srch_mode = 2'b10; exp_pos = 9'd200;
      send_word(WA, 9'd203, 1'b0, 1'b0);
      check_out("R6 outside +3", 1'b0, 9'd77);
      send_word(WA, 9'd202, 1'b0, 1'b0);
      check_out("R6 edge +2", 1'b1, 9'd202);
      pulse_clr();
      send_word(WA, 9'd198, 1'b0, 1'b0);
      check_out("R6 edge -2", 1'b1, 9'd198);
      pulse_clr();
      send_word(WA, 9'd197, 1'b0, 1'b0);
      check_out("R6 outside -3", 1'b0, 9'd198);
      srch_mode = 2'b11; exp_pos = 9'd1;
      send_word(WA, 9'd511, 1'b0, 1'b0);
      check_out("R6 wrap -2", 1'b1, 9'd511);
      pulse_clr();
      send_word(WA, 9'd510, 1'b0, 1'b0);
      check_out("R6 wrap -3", 1'b0, 9'd511);
      send_word(WA, 9'd3, 1'b0, 1'b0);
      check_out("R6 +2 mode 11", 1'b1, 9'd3);
   endtask

   task automatic t_collide();
      srch_mode = 2'b01; word_sel = 1'b1;
      send_word(WB, 9'd400, 1'b1, 1'b0);
      check_out("R8 clear with match", 1'b1, 9'd400);
      pulse_clr();
      check_out("R8 later clear", 1'b0, 9'd400);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_acq();
      t_select();
      t_gaps();
      t_off();
      t_track();
      t_collide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule